// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between a 32-bit core and an external bus whose ports may be 8, 16 or 32 bits wide. The core hands it one operand request of one, two or four bytes at any byte address. The block turns that request into as many bus cycles as needed. Each cycle presents the current byte address, a two-bit code for the bytes still to move, and a read or write indication. The external side ends every cycle with a two-bit active-low acknowledge, and that code tells the block how wide the responding port is.

Port width is not configured ahead of time. It is learned again from the acknowledge of every cycle. After each cycle, the block works out how many bytes that cycle really moved. That count is the port width minus the address offset inside the port, capped at the bytes left. The block then advances the address, lowers the remaining count, and starts the next cycle until nothing is left. On writes, operand bytes are placed on the data lanes so that whichever port width answers finds the correct byte on the lanes it samples. On reads, the bytes taken from the lanes are assembled in big-endian order.

Instruction prefetch always reads a whole aligned long word. The 32 fetched bits are kept in a holding register. A later fetch of either instruction word in that long word is served from the register without any bus cycle.

Top module: `dyn_size_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busStrobe` and `done` are 0 and `reqReady` is 1.
- R2: During every bus cycle, `busAddr` carries the current byte address. `busSize` carries the remaining byte count modulo four: 01 means one byte, 10 two, 11 three and 00 four.
- R3: `busAck` is active low. 00 ends a cycle from a 32-bit port, 01 (bit 1 low) ends it from a 16-bit port, and 10 (bit 0 low) ends it from an 8-bit port. 11 inserts a wait state, during which the strobe, address, size and direction stay unchanged.
- R4: Each acknowledged cycle moves min(port width − (address mod port width), remaining) bytes. The next cycle starts at the address advanced by that count, with the size code of the new remaining count.
- R5: A long word at byte offset 3 on a 32-bit port takes exactly two cycles. The first is at offset 3 with size 00. The second is at the next long-word address, offset 0, with size 11. A word at offset 1 on a 16-bit port starts with a cycle at offset 1 with size 10.
- R6: On writes, lane D31:24 carries the next operand byte to store. Every other lane carries the operand byte whose address maps to that lane for a port of any width. After the request, memory holds the operand in big-endian order.
- R7: Reads take bytes from lanes D31:24 (8-bit port), D31:16 (16-bit port) or D31:0 (32-bit port), at lane (address mod port width). `rdata` holds the operand right-justified in big-endian order and zero-extended.
- R8: `done` is a one-cycle pulse in the cycle after the final acknowledge. `reqReady` is 0 while a bus cycle is in progress, and `busStrobe` is 0 while `done` is 1.
- R9: A fetch request (`reqFetch`=1) reads at the long-word address with the two low bits forced to 00 and size 00. `rdata[15:0]` returns the instruction word selected by address bit 1: bit 1 = 0 selects the upper half, D31:16 of the long word.
- R10: A fetch in the same long word as the last completed fetch makes no bus cycle. Its `done` pulse comes in the cycle after acceptance, with the selected word from the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core presents a request |
| reqReady | output | 1 | Sequencer idle; the request is accepted on this edge |
| reqFetch | input | 1 | Request is an instruction prefetch |
| reqWrite | input | 1 | Request is an operand write (ignored for fetch) |
| reqLen | input | 2 | Operand length code: 01 one, 10 two, 00 four bytes |
| reqAddr | input | ADDR_W | Operand byte address |
| reqWdata | input | 32 | Write operand, right-justified |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read operand or fetched instruction word |
| busStrobe | output | 1 | A bus cycle is in progress |
| busWrite | output | 1 | Current cycle is a write |
| busAddr | output | ADDR_W | Current byte address |
| busSize | output | 2 | Remaining byte count code |
| busDataOut | output | 32 | Write data lanes |
| busDataIn | input | 32 | Read data lanes |
| busAck | input | 2 | Active-low cycle acknowledge and port width |

## Verification
The assertions take three things for granted about the inputs. `busAck` stays 11 whenever no bus cycle is active. It is never 00, 01 or 10 on two consecutive edges of the same cycle. The core does not raise a new request in the cycle `done` is high. The bench's responder models one port width per request. It waits a set number of wait states, acknowledges a cycle for exactly one clock, and returns the acknowledge to 11 on the next clock. The driver raises `reqValid` only when `reqReady` is high and waits for `done` before it sends the next request.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int CNT_W  = OFF_W + 1;
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic {
    ST_IDLE,
    ST_BUS
  } seqState_t;

  typedef struct packed {
    logic load;    // take a new request that needs the bus
    logic beat;    // current bus cycle acknowledged
    logic finish;  // acknowledged cycle was the last one
    logic hit;     // fetch served from the holding register
  } seqStrobe_t;

  // active-low acknowledge code -> port width in bytes (0 = wait)
  function automatic logic [CNT_W-1:0] ackBytes(input logic [1:0] ack);
    case (ack)
      2'b00:   ackBytes = CNT_W'(4);
      2'b01:   ackBytes = CNT_W'(2);
      2'b10:   ackBytes = CNT_W'(1);
      default: ackBytes = '0;
    endcase
  endfunction

  // request length code -> byte count
  function automatic logic [CNT_W-1:0] lenOfCode(input logic [1:0] code);
    lenOfCode = (code == 2'b00) ? CNT_W'(LANES) : CNT_W'(code);
  endfunction
endpackage

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqFetch,
  input  logic       holdHit,
  input  logic       lastBeat,
  input  logic [1:0] busAck,
  output seqStrobe_t strobe,
  output logic       busStrobe,
  output logic       reqReady,
  output logic       done
);
  seqState_t state, stateNext;

  logic isIdle, isBus, ackSeen;

  assign isIdle  = (state == ST_IDLE);
  assign isBus   = (state == ST_BUS);
  assign ackSeen = (busAck != 2'b11);

  always_comb begin
    strobe.hit    = isIdle & reqValid & reqFetch & holdHit;
    strobe.load   = isIdle & reqValid & ~(reqFetch & holdHit);
    strobe.beat   = isBus & ackSeen;
    strobe.finish = isBus & ackSeen & lastBeat;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strobe.load)   stateNext = ST_BUS;
      ST_BUS:  if (strobe.finish) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.finish | strobe.hit;
    end
  end

  assign busStrobe = isBus;
  assign reqReady  = isIdle;
endmodule

// File: rtl/dbs_datapath.sv
module dbs_datapath
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqLen,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        busAck,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busWrite,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rdata,
  output logic              holdHit,
  output logic              lastBeat
);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remCnt;
  logic [CNT_W-1:0]  lenReg;
  logic [DATA_W-1:0] wData;
  logic [DATA_W-1:0] asmReg;
  logic [DATA_W-1:0] asmNext;
  logic              isWrite;
  logic              isFetch;
  logic              wordSel;
  logic              holdValid;
  logic [TAG_W-1:0]  holdTag;
  logic [DATA_W-1:0] holdData;
  logic [CNT_W-1:0]  stepBytes;

  int portBytes, portOff, takeBytes, remInt, lenInt, nextIdx, curOff;

  // bytes taken by the acknowledged cycle and read assembly
  always_comb begin
    remInt    = int'(remCnt);
    lenInt    = int'(lenReg);
    curOff    = int'(curAddr[OFF_W-1:0]);
    portBytes = int'(ackBytes(busAck));
    portOff   = (portBytes == 0) ? 0 : (curOff & (portBytes - 1));
    takeBytes = portBytes - portOff;
    if (takeBytes > remInt) takeBytes = remInt;
    nextIdx   = lenInt - remInt;
    asmNext   = asmReg;
    for (int i = 0; i < LANES; i++) begin
      if (i < takeBytes) begin
        if ((portOff + i) < LANES && (nextIdx + i) < lenInt)
          asmNext[(lenInt - 1 - nextIdx - i)*8 +: 8] =
            busDataIn[(LANES - 1 - portOff - i)*8 +: 8];
      end
    end
  end

  assign stepBytes = CNT_W'(takeBytes);
  assign lastBeat  = (portBytes != 0) && (takeBytes == remInt);

  // write lane steering: each lane carries the byte any port width samples there
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    int          srcIdx;
    logic [7:0]  laneByte;
    always_comb begin
      if (k == 0)      srcIdx = nextIdx;
      else if (k == 1) srcIdx = nextIdx + 1 - (curOff & 1);
      else             srcIdx = nextIdx + k - curOff;
      if (isWrite && srcIdx >= 0 && srcIdx < lenInt)
        laneByte = wData[(lenInt - 1 - srcIdx)*8 +: 8];
      else
        laneByte = 8'h00;
    end
    assign busDataOut[(LANES-1-k)*8 +: 8] = laneByte;
  end

  assign busAddr  = curAddr;
  assign busSize  = remCnt[1:0];
  assign busWrite = isWrite;
  assign holdHit  = holdValid && (holdTag == reqAddr[ADDR_W-1:OFF_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      remCnt    <= '0;
      lenReg    <= '0;
      wData     <= '0;
      asmReg    <= '0;
      isWrite   <= 1'b0;
      isFetch   <= 1'b0;
      wordSel   <= 1'b0;
      holdValid <= 1'b0;
      holdTag   <= '0;
      holdData  <= '0;
      rdata     <= '0;
    end else begin
      if (strobe.load) begin
        curAddr <= reqFetch ? {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : reqAddr;
        remCnt  <= reqFetch ? CNT_W'(LANES) : lenOfCode(reqLen);
        lenReg  <= reqFetch ? CNT_W'(LANES) : lenOfCode(reqLen);
        wData   <= reqWdata;
        isWrite <= reqWrite & ~reqFetch;
        isFetch <= reqFetch;
        wordSel <= reqAddr[1];
        asmReg  <= '0;
      end
      if (strobe.beat) begin
        curAddr <= curAddr + ADDR_W'(stepBytes);
        remCnt  <= remCnt - stepBytes;
        asmReg  <= asmNext;
      end
      if (strobe.finish) begin
        if (isFetch) begin
          holdValid <= 1'b1;
          holdTag   <= curAddr[ADDR_W-1:OFF_W];
          holdData  <= asmNext;
          rdata     <= {{HALF_W{1'b0}}, wordSel ? asmNext[HALF_W-1:0] : asmNext[DATA_W-1:HALF_W]};
        end else begin
          rdata     <= isWrite ? '0 : asmNext;
        end
      end
      if (strobe.hit) begin
        rdata <= {{HALF_W{1'b0}}, reqAddr[1] ? holdData[HALF_W-1:0] : holdData[DATA_W-1:HALF_W]};
      end
    end
  end
endmodule

// File: rtl/dyn_size_seq.sv
module dyn_size_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqFetch,
  input  logic              reqWrite,
  input  logic [1:0]        reqLen,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              busStrobe,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [31:0]       busDataOut,
  input  logic [31:0]       busDataIn,
  input  logic [1:0]        busAck
);
  seqStrobe_t strobe;
  logic       holdHit;
  logic       lastBeat;

  dbs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqFetch  (reqFetch),
    .holdHit   (holdHit),
    .lastBeat  (lastBeat),
    .busAck    (busAck),
    .strobe    (strobe),
    .busStrobe (busStrobe),
    .reqReady  (reqReady),
    .done      (done)
  );

  dbs_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqWrite   (reqWrite),
    .reqFetch   (reqFetch),
    .reqWdata   (reqWdata),
    .busAck     (busAck),
    .busDataIn  (busDataIn),
    .busAddr    (busAddr),
    .busSize    (busSize),
    .busWrite   (busWrite),
    .busDataOut (busDataOut),
    .rdata      (rdata),
    .holdHit    (holdHit),
    .lastBeat   (lastBeat)
  );
endmodule

// File: rtl/dyn_size_seq_chk.sv
module dyn_size_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqFetch,
  input logic              done,
  input logic              busStrobe,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic [1:0]        busAck
);
  // R3: a wait state freezes the cycle
  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && busAck == 2'b11 |=> busStrobe && $stable(busAddr) && $stable(busSize) && $stable(busWrite));

  // R4: after a 32-bit acknowledge a continuing transfer is long-word aligned
  assert_wide_realign_R4: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && busAck == 2'b00 |=> !busStrobe || busAddr[1:0] == 2'b00);

  // R4: after a 16-bit acknowledge a continuing transfer is word aligned
  assert_half_realign_R4: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && busAck == 2'b01 |=> !busStrobe || busAddr[0] == 1'b0);

  // R9: an accepted fetch goes out as an aligned four-byte read
  assert_fetch_aligned_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqFetch |=> !busStrobe || (busAddr[1:0] == 2'b00 && busSize == 2'b00 && !busWrite));

  // R8: done is a single pulse unless a new request is taken with it
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done && !(reqValid && reqReady) |=> !done);

  // R8: not ready while a bus cycle runs
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |-> !reqReady);

  // R8: no bus cycle during the completion pulse
  assert_idle_on_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busStrobe);
endmodule

bind dyn_size_seq dyn_size_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqFetch  (reqFetch),
  .done      (done),
  .busStrobe (busStrobe),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busSize   (busSize),
  .busAck    (busAck)
);

// File: tb/dyn_size_seq_bench.sv
module dyn_size_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid, reqReady, reqFetch, reqWrite;
  logic [1:0]        reqLen;
  logic [ADDR_W-1:0] reqAddr;
  logic [31:0]       reqWdata;
  logic              done;
  logic [31:0]       rdata;
  logic              busStrobe, busWrite;
  logic [ADDR_W-1:0] busAddr;
  logic [1:0]        busSize;
  logic [31:0]       busDataOut, busDataIn;
  logic [1:0]        busAck;

  always #(CLK_PERIOD/2) clk = ~clk;

  dyn_size_seq #(.ADDR_W(ADDR_W)) u_dyn_size_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqFetch(reqFetch), .reqWrite(reqWrite), .reqLen(reqLen), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .done(done), .rdata(rdata), .busStrobe(busStrobe),
    .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize),
    .busDataOut(busDataOut), .busDataIn(busDataIn), .busAck(busAck)
  );

  int checks = 0;
  int errors = 0;
  int portW = 4;
  int waitStates = 0;
  int beatCount = 0;
  int doneCount = 0;
  logic [7:0] mem [256];

  logic [34:0] beatQ[$];
  string       beatTagQ[$];
  logic [31:0] resQ[$];
  logic        resChkQ[$];
  string       resTagQ[$];

  logic        modelHoldValid = 1'b0;
  logic [29:0] modelHoldTag = '0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder: wait states, then one-cycle acknowledge of the current port width
  initial begin
    int waitCnt;
    waitCnt = 0;
    busAck = 2'b11;
    busDataIn = '0;
    forever begin
      @(negedge clk);
      if (busAck != 2'b11) begin
        busAck = 2'b11;
        waitCnt = 0;
      end else if (rstN && busStrobe) begin
        if (beatQ.size() == 0) begin
          check("R2 unexpected bus cycle", {30'b0, busAddr, busSize}, 64'h0);
        end else if (waitCnt < waitStates) begin
          check({beatTagQ[0], " R3 wait address"}, busAddr, beatQ[0][34:3]);
          waitCnt++;
        end else begin
          logic [34:0] exp;
          string tg;
          int a, o, rem, tk, base;
          exp = beatQ.pop_front();
          tg  = beatTagQ.pop_front();
          check({tg, " R2 address"}, busAddr, exp[34:3]);
          check({tg, " R2 size"}, busSize, exp[2:1]);
          check({tg, " R2 direction"}, busWrite, exp[0]);
          check({tg, " R8 busy"}, reqReady, 1'b0);
          a    = int'(busAddr[7:0]);
          o    = a % portW;
          rem  = (busSize == 2'b00) ? 4 : int'(busSize);
          tk   = portW - o;
          if (tk > rem) tk = rem;
          base = a - o;
          busDataIn = 32'hEEEE_EEEE;
          for (int k = 0; k < portW; k++)
            busDataIn[31-8*k -: 8] = mem[(base + k) & 255];
          if (busWrite)
            for (int i = 0; i < tk; i++)
              mem[(a + i) & 255] = busDataOut[31-8*(o+i) -: 8];
          busAck = (portW == 4) ? 2'b00 : (portW == 2) ? 2'b01 : 2'b10;
          beatCount++;
        end
      end
    end
  end

  // result monitor
  initial begin
    logic prevDone;
    prevDone = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        string tg;
        logic  chk;
        logic [31:0] ev;
        check("R8 done single pulse", prevDone, 1'b0);
        if (resQ.size() == 0) begin
          check("R8 unexpected done", 1'b1, 1'b0);
        end else begin
          ev  = resQ.pop_front();
          chk = resChkQ.pop_front();
          tg  = resTagQ.pop_front();
          if (chk) check({tg, " rdata"}, rdata, ev);
        end
        doneCount++;
      end
      prevDone = done;
    end
  end

  task automatic pushBeats(int addr, int len, bit wr, string tg);
    int a, rem, t;
    a = addr; rem = len;
    while (rem > 0) begin
      t = portW - (a % portW);
      if (t > rem) t = rem;
      beatQ.push_back({32'(a), 2'(rem), wr});
      beatTagQ.push_back(tg);
      a += t; rem -= t;
    end
  endtask

  task automatic doReq(bit fetch, bit wr, int len, int addr, logic [31:0] wd, string tg);
    int startDone, startBeats;
    bit hit;
    logic [31:0] ev;
    startDone = doneCount;
    startBeats = beatCount;
    hit = 1'b0;
    ev = '0;
    if (fetch) begin
      int wa;
      hit = modelHoldValid && modelHoldTag == 30'(addr >> 2);
      if (!hit) pushBeats(addr & ~3, 4, 1'b0, tg);
      modelHoldValid = 1'b1;
      modelHoldTag = 30'(addr >> 2);
      wa = addr & ~1;
      ev = {16'h0, mem[wa & 255], mem[(wa + 1) & 255]};
    end else begin
      pushBeats(addr, len, wr, tg);
      for (int j = 0; j < len; j++) ev = (ev << 8) | 32'(mem[(addr + j) & 255]);
    end
    resQ.push_back(ev);
    resChkQ.push_back(!wr || fetch);
    resTagQ.push_back(tg);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqFetch = fetch;
    reqWrite = wr;
    reqLen   = (len == 4) ? 2'b00 : 2'(len);
    reqAddr  = ADDR_W'(addr);
    reqWdata = wd;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (hit) begin
      check({tg, " R10 done next cycle"}, done, 1'b1);
      check({tg, " R10 no bus cycle"}, 64'(beatCount), 64'(startBeats));
    end
    while (doneCount == startDone) @(negedge clk);
    if (wr && !fetch)
      for (int j = 0; j < len; j++)
        check({tg, " R6 memory byte"}, mem[(addr + j) & 255], wd[(len-1-j)*8 +: 8]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    rstN = 1'b0;
    reqValid = 1'b0; reqFetch = 1'b0; reqWrite = 1'b0;
    reqLen = 2'b00; reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    check("R1 strobe in reset", busStrobe, 1'b0);
    check("R1 done in reset", done, 1'b0);
    check("R1 ready in reset", reqReady, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 strobe after reset", busStrobe, 1'b0);
    check("R1 ready after reset", reqReady, 1'b1);

    portW = 4; waitStates = 0;
    doReq(0, 0, 4, 8'h10, '0, "R7 aligned long read 32");
    doReq(0, 0, 4, 8'h13, '0, "R5 long offset 3 read 32");
    portW = 2;
    doReq(0, 0, 2, 8'h21, '0, "R5 word offset 1 read 16");
    doReq(0, 0, 1, 8'h26, '0, "R7 byte read 16");
    portW = 1; waitStates = 2;
    doReq(0, 0, 4, 8'h31, '0, "R3 long read 8 waits");
    portW = 2; waitStates = 1;
    doReq(0, 0, 4, 8'h37, '0, "R4 long offset 3 read 16");
    portW = 4; waitStates = 0;
    doReq(0, 1, 4, 8'h53, 32'hA1B2C3D4, "R5 R6 long offset 3 write 32");
    doReq(0, 1, 2, 8'h5A, 32'h0000_9E8F, "R6 word offset 2 write 32");
    portW = 2;
    doReq(0, 1, 2, 8'h61, 32'h0000_7C6D, "R6 word offset 1 write 16");
    doReq(0, 1, 1, 8'h67, 32'h0000_005A, "R6 byte offset 3 write 16");
    portW = 1;
    doReq(0, 1, 4, 8'h72, 32'h1357_9BDF, "R6 long write 8");
    portW = 4;
    doReq(0, 0, 4, 8'h72, '0, "R7 readback after write");
    portW = 2;
    doReq(1, 0, 2, 8'h42, '0, "R9 fetch odd word 16");
    doReq(1, 0, 2, 8'h40, '0, "R10 fetch hit even word");
    doReq(1, 0, 2, 8'h42, '0, "R10 fetch hit odd word");
    portW = 4;
    doReq(1, 0, 2, 8'h45, '0, "R9 fetch miss 32");

    repeat (4) @(negedge clk);
    check("R2 leftover bus cycles", 64'(beatQ.size()), 64'h0);
    check("R8 leftover results", 64'(resQ.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule